// File: doc/BRIEF.md
# Quasi-Resonant Valley-Lockout Sequencer

This block times the switch turn-on of a quasi-resonant flyback controller. After each conduction interval it waits out the leakage ringing on the auxiliary-winding zero-crossing signal. It then counts the valleys of the drain ringing and pulses `turn_on` when the count reaches the valley the controller is locked into. A sampled feedback code in millivolts sets that valley. Each valley, and the foldback (low-power oscillator) mode below valley 4, has a separate entry threshold for falling feedback and a separate exit threshold for rising feedback. Because of this hysteresis, the selected valley holds until the load has changed by a clear margin.

Ringing can be too damped for the comparator to see. When no falling crossing arrives within a timeout window, the block counts a substitute valley. The window is much longer while soft-start is in progress, so that the core has fully reset before the next turn-on. The feedback tracker changes state freely, but the mode used for counting is copied from it only when an on-time ends. A mode change therefore never lands in the middle of a count. In foldback mode the block only reports the mode and issues no turn-on.

Top module: `qrv_valley_sequencer`

## Requirements
- R1: During and after reset the tracked mode and the running mode both read valley 1 (code 1), and `turn_on` is low.
- R2: Mode codes are 1 to 4 for valleys 1 to 4 and 0 for foldback. The tracker steps one position per clock toward lighter load when feedback is strictly below the falling threshold of its current state: valley 1 below 1400 mV, valley 2 below 1200 mV, valley 3 below 900 mV, valley 4 below 800 mV (to foldback).
- R3: The tracker steps one position per clock toward heavier load when feedback is strictly above the rising threshold of its current state: foldback above 1400 mV (to valley 4), valley 4 above 1600 mV, valley 3 above 1800 mV, valley 2 above 2000 mV (to valley 1).
- R4: Feedback between a state's two thresholds, or exactly on a threshold, leaves the tracked mode unchanged.
- R5: Each falling edge of `zc_in` counts one valley. When the count reaches the running mode, `turn_on` goes high for exactly one clock, in the clock after the edge that completed the count.
- R6: Zero-crossing edges in the `BLANK_TICKS` clocks after the clock that accepts `ton_end` are not counted.
- R7: With `ss_done` high, if no valley has been counted for `TOUT_TICKS` clocks since blanking ended or since the last counted valley, a substitute valley is counted.
- R8: With `ss_done` low, the substitute-valley window is `TOUT_SS_TICKS` clocks instead.
- R9: The running mode is loaded from the tracked mode only in the clock that accepts `ton_end`. Tracker changes during counting do not alter the running mode or the valley at which `turn_on` fires.
- R10: While the running mode is foldback, no `turn_on` is issued, whatever `zc_in` does.
- R11: The valley count clears with each `turn_on`, so every switching cycle counts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_mv | input | FB_W | Feedback sample, unsigned millivolts |
| zc_in | input | 1 | Zero-crossing comparator output; falling edge marks a valley |
| ss_done | input | 1 | High once soft-start has finished |
| ton_end | input | 1 | One-clock pulse at the end of each on-time |
| turn_on | output | 1 | One-clock pulse requesting switch turn-on |
| sel_mode | output | 3 | Tracked mode from the feedback lockout (0 foldback, 1..4 valley) |
| run_mode | output | 3 | Mode used by the current switching cycle |

## Verification
Feedback is swept down through every falling threshold and back up through every rising one. It is also held on a threshold and inside the dead band, which separates a correct hysteresis from a single-threshold comparator. Switching cycles are driven three ways: with a real zero-crossing edge, with edges hidden inside the blanking window, and with timeouts only (both soft-start states). The cycle in which `turn_on` appears shows whether the blanking length, the timeout length, or the count target is wrong. One valley-3 cycle mixes an edge with two timeouts and moves feedback to heavy load mid-count, which shows whether the running mode is latched. A foldback cycle with toggling zero-crossing input must produce no pulse at all.

// File: rtl/qrv_pkg.sv
package qrv_pkg;

    typedef enum logic [2:0] {
        MODE_FOLD = 3'd0,
        MODE_V1   = 3'd1,
        MODE_V2   = 3'd2,
        MODE_V3   = 3'd3,
        MODE_V4   = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        PH_ON    = 2'd0,
        PH_BLANK = 2'd1,
        PH_COUNT = 2'd2
    } phase_e;

endpackage

// File: rtl/qrv_lockout.sv
module qrv_lockout
    import qrv_pkg::*;
#(
    parameter int FB_W    = 12,
    parameter int TH_1TO2 = 1400,
    parameter int TH_2TO3 = 1200,
    parameter int TH_3TO4 = 900,
    parameter int TH_4TOF = 800,
    parameter int TH_FTO4 = 1400,
    parameter int TH_4TO3 = 1600,
    parameter int TH_3TO2 = 1800,
    parameter int TH_2TO1 = 2000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FB_W-1:0] fb_mv,
    output mode_e           mode_o
);

    localparam logic [FB_W-1:0] DN_12 = FB_W'(TH_1TO2);
    localparam logic [FB_W-1:0] DN_23 = FB_W'(TH_2TO3);
    localparam logic [FB_W-1:0] DN_34 = FB_W'(TH_3TO4);
    localparam logic [FB_W-1:0] DN_4F = FB_W'(TH_4TOF);
    localparam logic [FB_W-1:0] UP_F4 = FB_W'(TH_FTO4);
    localparam logic [FB_W-1:0] UP_43 = FB_W'(TH_4TO3);
    localparam logic [FB_W-1:0] UP_32 = FB_W'(TH_3TO2);
    localparam logic [FB_W-1:0] UP_21 = FB_W'(TH_2TO1);

    typedef struct packed {
        mode_e mode;
    } lock_t;

    lock_t lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        unique case (lock_q.mode)
            MODE_V1: begin
                if (fb_mv < DN_12) lock_d.mode = MODE_V2;
            end
            MODE_V2: begin
                if (fb_mv < DN_23)      lock_d.mode = MODE_V3;
                else if (fb_mv > UP_21) lock_d.mode = MODE_V1;
            end
            MODE_V3: begin
                if (fb_mv < DN_34)      lock_d.mode = MODE_V4;
                else if (fb_mv > UP_32) lock_d.mode = MODE_V2;
            end
            MODE_V4: begin
                if (fb_mv < DN_4F)      lock_d.mode = MODE_FOLD;
                else if (fb_mv > UP_43) lock_d.mode = MODE_V3;
            end
            MODE_FOLD: begin
                if (fb_mv > UP_F4) lock_d.mode = MODE_V4;
            end
            default: lock_d.mode = MODE_V1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= '{mode: MODE_V1};
        else        lock_q <= lock_d;
    end

    assign mode_o = lock_q.mode;

endmodule

// File: rtl/qrv_zc_edge.sv
module qrv_zc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic zc_in,
    output logic fall_o
);

    typedef struct packed {
        logic zc;
    } edge_t;

    edge_t edge_d, edge_q;

    always_comb begin
        edge_d    = edge_q;
        edge_d.zc = zc_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) edge_q <= '{zc: 1'b0};
        else        edge_q <= edge_d;
    end

    assign fall_o = edge_q.zc & ~zc_in;

endmodule

// File: rtl/qrv_cycle_fsm.sv
module qrv_cycle_fsm
    import qrv_pkg::*;
#(
    parameter int BLANK_TICKS   = 150,
    parameter int TOUT_TICKS    = 295,
    parameter int TOUT_SS_TICKS = 2000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e sel_mode_i,
    input  logic  fall_i,
    input  logic  ss_done_i,
    input  logic  ton_end_i,
    output logic  turn_on_o,
    output mode_e run_mode_o
);

    localparam int MAX_AB = (BLANK_TICKS > TOUT_TICKS) ? BLANK_TICKS : TOUT_TICKS;
    localparam int MAX_T  = (MAX_AB > TOUT_SS_TICKS) ? MAX_AB : TOUT_SS_TICKS;
    localparam int TW     = $clog2(MAX_T + 1);

    localparam logic [TW-1:0] BLANK_LAST = TW'(BLANK_TICKS - 1);
    localparam logic [TW-1:0] TOUT_LAST  = TW'(TOUT_TICKS - 1);
    localparam logic [TW-1:0] TSS_LAST   = TW'(TOUT_SS_TICKS - 1);

    typedef struct packed {
        phase_e        phase;
        mode_e         run;
        logic [2:0]    cnt;
        logic [TW-1:0] tick;
        logic          fire;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic [TW-1:0] win_last;
    logic          valley_ev;
    logic [2:0]    cnt_inc;

    always_comb begin
        win_last  = ss_done_i ? TOUT_LAST : TSS_LAST;
        valley_ev = fall_i || (fsm_q.tick == win_last);
        cnt_inc   = fsm_q.cnt + 3'd1;

        fsm_d      = fsm_q;
        fsm_d.fire = 1'b0;

        unique case (fsm_q.phase)
            PH_ON: begin
                if (ton_end_i) begin
                    fsm_d.run  = sel_mode_i;
                    fsm_d.tick = '0;
                    fsm_d.cnt  = '0;
                    if (sel_mode_i != MODE_FOLD) fsm_d.phase = PH_BLANK;
                end
            end
            PH_BLANK: begin
                if (fsm_q.tick == BLANK_LAST) begin
                    fsm_d.phase = PH_COUNT;
                    fsm_d.tick  = '0;
                end else begin
                    fsm_d.tick = fsm_q.tick + 1'b1;
                end
            end
            PH_COUNT: begin
                if (valley_ev) begin
                    fsm_d.tick = '0;
                    if (cnt_inc == 3'(fsm_q.run)) begin
                        fsm_d.fire  = 1'b1;
                        fsm_d.cnt   = '0;
                        fsm_d.phase = PH_ON;
                    end else begin
                        fsm_d.cnt = cnt_inc;
                    end
                end else begin
                    fsm_d.tick = fsm_q.tick + 1'b1;
                end
            end
            default: fsm_d.phase = PH_ON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= '{phase: PH_ON, run: MODE_V1, cnt: 3'd0, tick: '0, fire: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign turn_on_o  = fsm_q.fire;
    assign run_mode_o = fsm_q.run;

endmodule

// File: rtl/qrv_valley_sequencer.sv
module qrv_valley_sequencer
    import qrv_pkg::*;
#(
    parameter int FB_W          = 12,
    parameter int BLANK_TICKS   = 150,
    parameter int TOUT_TICKS    = 295,
    parameter int TOUT_SS_TICKS = 2000,
    parameter int TH_1TO2       = 1400,
    parameter int TH_2TO3       = 1200,
    parameter int TH_3TO4       = 900,
    parameter int TH_4TOF       = 800,
    parameter int TH_FTO4       = 1400,
    parameter int TH_4TO3       = 1600,
    parameter int TH_3TO2       = 1800,
    parameter int TH_2TO1       = 2000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FB_W-1:0] fb_mv,
    input  logic            zc_in,
    input  logic            ss_done,
    input  logic            ton_end,
    output logic            turn_on,
    output logic [2:0]      sel_mode,
    output logic [2:0]      run_mode
);

    mode_e tracked;
    mode_e running;
    logic  zc_fall;

    qrv_lockout #(
        .FB_W(FB_W),
        .TH_1TO2(TH_1TO2), .TH_2TO3(TH_2TO3), .TH_3TO4(TH_3TO4), .TH_4TOF(TH_4TOF),
        .TH_FTO4(TH_FTO4), .TH_4TO3(TH_4TO3), .TH_3TO2(TH_3TO2), .TH_2TO1(TH_2TO1)
    ) u_lockout (
        .clk   (clk),
        .rst_n (rst_n),
        .fb_mv (fb_mv),
        .mode_o(tracked)
    );

    qrv_zc_edge u_zc_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .zc_in (zc_in),
        .fall_o(zc_fall)
    );

    qrv_cycle_fsm #(
        .BLANK_TICKS  (BLANK_TICKS),
        .TOUT_TICKS   (TOUT_TICKS),
        .TOUT_SS_TICKS(TOUT_SS_TICKS)
    ) u_cycle (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_mode_i(tracked),
        .fall_i    (zc_fall),
        .ss_done_i (ss_done),
        .ton_end_i (ton_end),
        .turn_on_o (turn_on),
        .run_mode_o(running)
    );

    assign sel_mode = 3'(tracked);
    assign run_mode = 3'(running);

endmodule

// File: rtl/qrv_seq_checker.sv
module qrv_seq_checker #(
    parameter int FB_W        = 12,
    parameter int BLANK_TICKS = 150,
    parameter int TH_1TO2     = 1400,
    parameter int TH_FTO4     = 1400
) (
    input logic            clk,
    input logic            rst_n,
    input logic [FB_W-1:0] fb_mv,
    input logic            ton_end,
    input logic            turn_on,
    input logic [2:0]      sel_mode,
    input logic [2:0]      run_mode
);

    int unsigned since_q;
    logic        armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= 0;
            armed_q <= 1'b1;
        end else begin
            if (turn_on) armed_q <= 1'b1;
            else if (ton_end && armed_q) armed_q <= 1'b0;
            if (ton_end && armed_q) since_q <= 0;
            else if (since_q < BLANK_TICKS + 1) since_q <= since_q + 1;
        end
    end

    assert_mode_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_mode <= 3'd4);

    assert_fall_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_mode) == 3'd1 && sel_mode == 3'd2) |-> ($past(fb_mv) < FB_W'(TH_1TO2)));

    assert_rise_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_mode) == 3'd0 && sel_mode == 3'd4) |-> ($past(fb_mv) > FB_W'(TH_FTO4)));

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        turn_on |=> !turn_on);

    assert_blank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        turn_on |-> (since_q >= BLANK_TICKS));

    assert_run_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ton_end) |-> $stable(run_mode));

    assert_fold_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        turn_on |-> (run_mode != 3'd0));

endmodule

bind qrv_valley_sequencer qrv_seq_checker #(
    .FB_W(FB_W), .BLANK_TICKS(BLANK_TICKS), .TH_1TO2(TH_1TO2), .TH_FTO4(TH_FTO4)
) u_seq_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .fb_mv   (fb_mv),
    .ton_end (ton_end),
    .turn_on (turn_on),
    .sel_mode(sel_mode),
    .run_mode(run_mode)
);

// File: tb/test_qrv_valley_sequencer.sv
module test_qrv_valley_sequencer;

    localparam int FB_W = 12;
    localparam int B    = 8;
    localparam int L    = 20;
    localparam int LS   = 60;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [FB_W-1:0] fb_mv = 12'd2500;
    logic            zc_in = 1'b1;
    logic            ss_done = 1'b1;
    logic            ton_end = 1'b0;
    logic            turn_on;
    logic [2:0]      sel_mode;
    logic [2:0]      run_mode;

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    int    pulses = 0;
    int    exp_q[$];
    string tag_q[$];
    bit    done = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    qrv_valley_sequencer #(
        .FB_W(FB_W), .BLANK_TICKS(B), .TOUT_TICKS(L), .TOUT_SS_TICKS(LS)
    ) i_qrv_valley_sequencer (
        .clk(clk), .rst_n(rst_n), .fb_mv(fb_mv), .zc_in(zc_in),
        .ss_done(ss_done), .ton_end(ton_end), .turn_on(turn_on),
        .sel_mode(sel_mode), .run_mode(run_mode)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input int at, input string req);
        exp_q.push_back(at);
        tag_q.push_back(req);
    endtask

    // monitor: compares each turn_on pulse against the scoreboard
    always @(negedge clk) begin
        if (rst_n && turn_on) begin
            pulses++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5/R10 unexpected turn_on", cyc, -1);
            end else begin
                automatic int    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(cyc == e, t, cyc, e);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic end_on(output int p0);
        ton_end = 1'b1;
        p0 = cyc + 1;
        @(negedge clk);
        ton_end = 1'b0;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) begin
            @(negedge clk);
            #1;
        end
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic set_fb(input int v, input int expm, input string req);
        fb_mv = FB_W'(v);
        step(6);
        chk(sel_mode == 3'(expm), req, sel_mode, expm);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int p0;
        int pc;
        step(4);
        // R1: reset state
        chk(sel_mode == 3'd1, "R1 sel_mode in reset", sel_mode, 1);
        chk(run_mode == 3'd1, "R1 run_mode in reset", run_mode, 1);
        chk(turn_on == 1'b0, "R1 turn_on in reset", turn_on, 0);
        rst_n = 1'b1;
        step(3);
        chk(sel_mode == 3'd1 && run_mode == 3'd1, "R1 mode after release", sel_mode, 1);

        // R5: valley 1 from a real falling edge
        end_on(p0);
        step(B + 2);
        zc_in = 1'b0;
        push(cyc + 1, "R5 edge-driven valley 1");
        step(1);
        zc_in = 1'b1;
        drain("R5 pulse seen");

        // R6: edge inside blanking ignored, timeout supplies valley (R7)
        end_on(p0);
        step(2);
        zc_in = 1'b0;
        step(2);
        zc_in = 1'b1;
        push(p0 + B + L, "R6/R7 blanked edge, timeout valley");
        drain("R6 pulse seen");

        // R8: soft-start timeout
        ss_done = 1'b0;
        end_on(p0);
        push(p0 + B + LS, "R8 soft-start timeout");
        drain("R8 pulse seen");
        ss_done = 1'b1;

        // R2/R3/R4: lockout sweep
        set_fb(1400, 1, "R4 on threshold holds valley 1");
        set_fb(1300, 2, "R2 below 1400 to valley 2");
        set_fb(1500, 2, "R4 dead band holds valley 2");
        set_fb(1100, 3, "R2 below 1200 to valley 3");
        set_fb(850, 4, "R2 below 900 to valley 4");
        set_fb(700, 0, "R2 below 800 to foldback");
        set_fb(1300, 0, "R4 foldback holds at 1300");
        set_fb(1500, 4, "R3 above 1400 to valley 4");
        set_fb(1700, 3, "R3 above 1600 to valley 3");
        set_fb(1900, 2, "R3 above 1800 to valley 2");
        set_fb(2100, 1, "R3 above 2000 to valley 1");

        // R9/R7: valley 3 with one edge, two timeouts, mid-count mode change
        set_fb(1100, 3, "R2 multi-step to valley 3");
        end_on(p0);
        chk(run_mode == 3'd3, "R9 run_mode latched at ton_end", run_mode, 3);
        step(B + 2);
        zc_in = 1'b0;
        push(cyc + 1 + 2 * L, "R7/R9 valley 3 after edge and timeouts");
        step(1);
        zc_in = 1'b1;
        fb_mv = 12'd2500;
        step(6);
        chk(sel_mode == 3'd1, "R9 tracker moved mid-count", sel_mode, 1);
        chk(run_mode == 3'd3, "R9 run_mode held mid-count", run_mode, 3);
        drain("R9 pulse seen");

        // R11: next cycle counts from zero in valley 1
        end_on(p0);
        chk(run_mode == 3'd1, "R9 new mode at next boundary", run_mode, 1);
        push(p0 + B + L, "R11 count restarts");
        drain("R11 pulse seen");

        // R10: foldback issues nothing
        set_fb(700, 0, "R2 sweep to foldback");
        pc = pulses;
        end_on(p0);
        chk(run_mode == 3'd0, "R10 run_mode foldback", run_mode, 0);
        for (int k = 0; k < 10; k++) begin
            step(B + 3);
            zc_in = 1'b0;
            step(2);
            zc_in = 1'b1;
        end
        step(5 * L);
        chk(pulses == pc, "R10 no turn_on in foldback", pulses - pc, 0);

        fb_mv = 12'd2500;
        step(8);
        end_on(p0);
        push(p0 + B + L, "R10 leaves foldback at boundary");
        drain("R10 recovery pulse seen");

        step(5);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule